// File: doc/BRIEF.md
# Bus Initiator Error Status Unit

This unit sits beside the master-side state machine of a parallel bus controller and turns three kinds of failed transfer into sticky status flags. A per-transaction counter tallies retry disconnects and raises a retry error when the tally reaches a programmable limit. A claim timer, started by each address phase, raises an initiator abort when no target asserts device-select in time. A target-abort strobe from the state machine raises the third flag. All events arrive as single-cycle strobes.

Software reads the three flags in one 32-bit status word and clears them by writing ones. Each flag has its own enable. A single registered interrupt line is high while any enabled flag is set.

Top module: `init_err_status`

## Requirements
- R1: After reset the status word reads 0x00000000 and `irq` is low.
- R2: The status word carries the retry error at bit 26, the initiator abort at bit 25 and the target abort at bit 24 (bits 5, 6 and 7 counted from the msb). Every other bit reads zero.
- R3: With a nonzero `retry_limit`, the retry-error flag sets on the edge that samples the retry strobe which brings the count for the current transaction up to the limit. Further retries in that transaction do not wrap the count and set nothing new.
- R4: With `retry_limit` at 0x00, retries are not counted and the retry-error flag never sets.
- R5: The retry count returns to zero on `txn_start` and on `txn_done`. A retry strobe in the same cycle as either is not counted.
- R6: After an `addr_phase` strobe, the initiator-abort flag sets on the edge of the `claim_window`-th following cycle (a window of 0 acts as 1), unless `devsel` is seen in one of those cycles. A `devsel` in the last cycle still cancels the timeout, and a new `addr_phase` restarts the window.
- R7: A `target_abort` strobe sets the target-abort flag.
- R8: A write with `wr_en` high clears every flag whose bit in `wr_data` is 1. Flags written with 0 keep their value. Flags stay set without a clear.
- R9: If a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R10: `irq` is registered. On each edge it takes the OR over the three flags of (flag AND its `irq_en` bit, where bit 2 is the retry error, bit 1 the initiator abort and bit 0 the target abort), using the flag values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Status write strobe (write 1 to clear) |
| wr_data | input | 32 | Write data. Bits 26/25/24 clear the flags |
| rd_data | output | 32 | Status word |
| retry_limit | input | 8 | Retry limit. 0 means unlimited |
| claim_window | input | 8 | Cycles allowed for device-select |
| irq_en | input | 3 | Interrupt enables {retry, initiator abort, target abort} |
| txn_start | input | 1 | New transaction begins |
| txn_done | input | 1 | Transaction ended other than by retry |
| addr_phase | input | 1 | Address phase begins |
| devsel | input | 1 | Target claimed the cycle |
| retry | input | 1 | Target issued a retry disconnect |
| target_abort | input | 1 | Target signalled an abort |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a device-select that arrives in exactly the last cycle of the claim window. One cycle earlier is an ordinary cancel, and one cycle later is a timeout. The stimulus table counts cycles from the address-phase strobe and places `devsel` precisely on the window's final cycle. The same care goes into the retry limit, which is tested at 1, at 3 with a completion in the middle, and at 0, and into the case where a set and a clear hit a flag in the same cycle.

// File: rtl/ies_pkg.sv
package ies_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_FLAGS = 3;

  // lsb-indexed positions inside the status word (decoded by software)
  localparam int unsigned POS_RETRY = 26;
  localparam int unsigned POS_IABRT = 25;
  localparam int unsigned POS_TABRT = 24;

  // flag vector order: [2] retry error, [1] initiator abort, [0] target abort
  localparam int unsigned IDX_RETRY = 2;
  localparam int unsigned IDX_IABRT = 1;
  localparam int unsigned IDX_TABRT = 0;

  function automatic logic [WORD_W-1:0] pack_status(input logic [N_FLAGS-1:0] f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_RETRY] = f[IDX_RETRY];
    w[POS_IABRT] = f[IDX_IABRT];
    w[POS_TABRT] = f[IDX_TABRT];
    return w;
  endfunction

  function automatic logic [N_FLAGS-1:0] unpack_clear(input logic [WORD_W-1:0] w);
    logic [N_FLAGS-1:0] m;
    m[IDX_RETRY] = w[POS_RETRY];
    m[IDX_IABRT] = w[POS_IABRT];
    m[IDX_TABRT] = w[POS_TABRT];
    return m;
  endfunction

endpackage

// File: rtl/ies_retry_tracker.sv
module ies_retry_tracker #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_start,
  input  logic             clr_done,
  input  logic             retry,
  input  logic [LIM_W-1:0] limit,
  output logic             retry_err,
  output logic [LIM_W-1:0] count
);

  localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};

  function automatic logic [LIM_W-1:0] sat_inc(input logic [LIM_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic reaches_limit(input logic [LIM_W-1:0] c,
                                         input logic [LIM_W-1:0] l);
    logic [LIM_W:0] nxt;
    nxt = {1'b0, c} + 1'b1;
    return (l != '0) && (nxt == {1'b0, l});
  endfunction

  logic clr_any;
  logic counting;

  assign clr_any   = clr_start | clr_done;
  assign counting  = retry && !clr_any && (limit != '0);
  assign retry_err = counting && reaches_limit(count, limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (clr_any)  count <= '0;
    else if (counting) count <= sat_inc(count);
  end

  AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !retry_err); // R4
  AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (count == '0)); // R5
  AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    counting |=> (count != '0)); // R3

endmodule

// File: rtl/ies_claim_timer.sv
module ies_claim_timer #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             devsel,
  input  logic [WIN_W-1:0] window,
  output logic             timeout,
  output logic             armed
);

  logic [WIN_W-1:0] remain;

  function automatic logic [WIN_W-1:0] load_value(input logic [WIN_W-1:0] w);
    return (w == '0) ? {{(WIN_W-1){1'b0}}, 1'b1} : w;
  endfunction

  logic last_cycle;
  assign last_cycle = (remain == {{(WIN_W-1){1'b0}}, 1'b1});
  assign timeout    = armed && !devsel && !addr_phase && last_cycle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (addr_phase) begin
      armed  <= 1'b1;
      remain <= load_value(window);
    end else if (armed) begin
      if (devsel || last_cycle) armed <= 1'b0;
      else                      remain <= remain - 1'b1;
    end
  end

  AST_TIMEOUT_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> armed); // R6
  AST_DEVSEL_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && devsel && !addr_phase) |=> !armed); // R6
  AST_TIMEOUT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !armed); // R6

endmodule

// File: rtl/ies_flag_bank.sv
module ies_flag_bank #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr_req,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags,
  output logic          irq
);

  logic [NF-1:0] active_src;
  assign active_src = flags & en;

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)         flags[i] <= 1'b0;
        else if (set_ev[i]) flags[i] <= 1'b1;
        else if (clr_req[i]) flags[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[i] |=> flags[i]); // R9
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !clr_req[i]) |=> flags[i]); // R8
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req[i] && !set_ev[i]) |=> !flags[i]); // R8
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |active_src;
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(flags & en)))); // R10

endmodule

// File: rtl/init_err_status.sv
module init_err_status
  import ies_pkg::*;
#(
  parameter int unsigned LIM_W = 8,
  parameter int unsigned WIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic [LIM_W-1:0]  retry_limit,
  input  logic [WIN_W-1:0]  claim_window,
  input  logic [N_FLAGS-1:0] irq_en,
  input  logic              txn_start,
  input  logic              txn_done,
  input  logic              addr_phase,
  input  logic              devsel,
  input  logic              retry,
  input  logic              target_abort,
  output logic              irq
);

  // internal events brought out as named wires
  logic               ev_retry_err;
  logic               ev_claim_tmo;
  logic               tmr_armed;
  logic [LIM_W-1:0]   retry_count;
  logic [N_FLAGS-1:0] set_vec;
  logic [N_FLAGS-1:0] clr_vec;
  logic [N_FLAGS-1:0] flag_q;

  ies_retry_tracker #(.LIM_W(LIM_W)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_start (txn_start),
    .clr_done  (txn_done),
    .retry     (retry),
    .limit     (retry_limit),
    .retry_err (ev_retry_err),
    .count     (retry_count)
  );

  ies_claim_timer #(.WIN_W(WIN_W)) u_claim (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase),
    .devsel     (devsel),
    .window     (claim_window),
    .timeout    (ev_claim_tmo),
    .armed      (tmr_armed)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[IDX_RETRY] = ev_retry_err;
    set_vec[IDX_IABRT] = ev_claim_tmo;
    set_vec[IDX_TABRT] = target_abort;
  end

  assign clr_vec = wr_en ? unpack_clear(wr_data) : '0;

  ies_flag_bank #(.NF(N_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_vec),
    .clr_req (clr_vec),
    .en      (irq_en),
    .flags   (flag_q),
    .irq     (irq)
  );

  assign rd_data = pack_status(flag_q);

  AST_TABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    target_abort |=> rd_data[POS_TABRT]); // R7
  AST_RETRY_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry_err |=> rd_data[POS_RETRY]); // R3
  AST_NO_RETRY_WHEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start || txn_done) |-> !ev_retry_err); // R5

endmodule

// File: tb/sim_init_err_status.sv
module sim_init_err_status;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  retry_limit = 8'd3;
  logic [7:0]  claim_window = 8'd4;
  logic [2:0]  irq_en = 3'b111;
  logic        txn_start = 1'b0, txn_done = 1'b0, addr_phase = 1'b0;
  logic        devsel = 1'b0, retry = 1'b0, target_abort = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_err_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .retry_limit(retry_limit), .claim_window(claim_window), .irq_en(irq_en),
    .txn_start(txn_start), .txn_done(txn_done), .addr_phase(addr_phase),
    .devsel(devsel), .retry(retry), .target_abort(target_abort), .irq(irq)
  );

  // status word as the requirements define it: bit 26 retry, 25 init abort, 24 target abort
  function automatic logic [31:0] word_of(input logic [2:0] f);
    return {5'b0, f, 24'b0};
  endfunction

  // [15] wr [14:12] clear{re,ia,ta} [11] start [10] addr [9] devsel [8] retry
  // [7] done [6] tabort [5:3] expected flags{re,ia,ta} [2] expected irq [1:0] unused
  // limit 3, window 4, all enables on
  localparam logic [15:0] TBL [NVEC] = '{
    16'b0_000_1_0_0_0_0_0_000_0_00, // 0 start
    16'b0_000_0_0_0_1_0_0_000_0_00, // 1 retry 1
    16'b0_000_0_0_0_1_0_0_000_0_00, // 2 retry 2
    16'b0_000_0_0_0_0_1_0_000_0_00, // 3 done clears R5
    16'b0_000_0_0_0_1_0_0_000_0_00, // 4 retry 1
    16'b0_000_0_0_0_1_0_0_000_0_00, // 5 retry 2
    16'b0_000_0_0_0_1_0_0_100_0_00, // 6 retry 3 -> R3
    16'b0_000_0_0_0_0_0_0_100_1_00, // 7 irq R10
    16'b0_000_0_0_0_1_0_0_100_1_00, // 8 extra retry
    16'b1_100_0_0_0_0_0_0_000_1_00, // 9 clear R8
    16'b0_000_0_0_0_0_0_0_000_0_00, // 10
    16'b0_000_0_0_0_0_0_1_001_0_00, // 11 tabort R7
    16'b1_010_0_0_0_0_0_0_001_1_00, // 12 clear other bit R8
    16'b1_001_0_0_0_0_0_1_001_1_00, // 13 set beats clear R9
    16'b1_001_0_0_0_0_0_0_000_1_00, // 14 clear
    16'b0_000_0_1_0_0_0_0_000_0_00, // 15 addr
    16'b0_000_0_0_0_0_0_0_000_0_00, // 16
    16'b0_000_0_0_1_0_0_0_000_0_00, // 17 devsel cancels R6
    16'b0_000_0_0_0_0_0_0_000_0_00, // 18
    16'b0_000_0_0_0_0_0_0_000_0_00, // 19
    16'b0_000_0_0_0_0_0_0_000_0_00, // 20
    16'b0_000_0_0_0_0_0_0_000_0_00, // 21
    16'b0_000_0_1_0_0_0_0_000_0_00, // 22 addr
    16'b0_000_0_0_0_0_0_0_000_0_00, // 23
    16'b0_000_0_0_0_0_0_0_000_0_00, // 24
    16'b0_000_0_0_0_0_0_0_000_0_00, // 25
    16'b0_000_0_0_0_0_0_0_010_0_00, // 26 timeout R6
    16'b0_000_0_0_0_0_0_0_010_1_00, // 27
    16'b1_111_0_0_0_0_0_0_000_1_00, // 28 clear all
    16'b0_000_0_0_0_0_0_0_000_0_00, // 29
    16'b0_000_0_1_0_0_0_0_000_0_00, // 30 addr
    16'b0_000_0_0_0_0_0_0_000_0_00, // 31
    16'b0_000_0_0_0_0_0_0_000_0_00, // 32
    16'b0_000_0_0_0_0_0_0_000_0_00, // 33
    16'b0_000_0_0_1_0_0_0_000_0_00, // 34 devsel on last cycle R6
    16'b0_000_0_0_0_0_0_0_000_0_00  // 35
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ev = {start, addr, devsel, retry, done, tabort}
  task automatic step(input logic [5:0] ev, input logic w, input logic [2:0] clr);
    @(negedge clk);
    {txn_start, addr_phase, devsel, retry, txn_done, target_abort} = ev;
    wr_en   = w;
    wr_data = w ? word_of(clr) : 32'h0;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(6'b0, 1'b0, 3'b0);
  endtask

  task automatic clear_all();
    step(6'b0, 1'b1, 3'b111);
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 status at reset", rd_data, 32'h0);
    chk("R1 irq at reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk("R1 status after release", rd_data, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      step(TBL[v][11:6], TBL[v][15], TBL[v][14:12]);
      chk($sformatf("R3/R6/R7/R8/R9 vec %0d flags", v), rd_data, word_of(TBL[v][5:3]));
      chk($sformatf("R10 vec %0d irq", v), {31'b0, irq}, {31'b0, TBL[v][2]});
    end

    // R4: zero limit never flags
    retry_limit = 8'd0;
    step(6'b100000, 1'b0, 3'b0);
    for (int k = 0; k < 300; k++) step(6'b000100, 1'b0, 3'b0);
    chk("R4 zero limit", rd_data, 32'h0);

    // R3: limit 1 flags on first retry
    retry_limit = 8'd1;
    step(6'b100000, 1'b0, 3'b0);
    step(6'b000100, 1'b0, 3'b0);
    chk("R3 limit one", rd_data, word_of(3'b100));
    clear_all();

    // R5: start clears the count
    retry_limit = 8'd3;
    step(6'b100000, 1'b0, 3'b0);
    step(6'b000100, 1'b0, 3'b0);
    step(6'b000100, 1'b0, 3'b0);
    step(6'b100000, 1'b0, 3'b0);
    step(6'b000100, 1'b0, 3'b0);
    step(6'b000100, 1'b0, 3'b0);
    chk("R5 start clears count", rd_data, 32'h0);
    step(6'b100100, 1'b0, 3'b0); // retry with start: not counted
    step(6'b000100, 1'b0, 3'b0);
    step(6'b000100, 1'b0, 3'b0);
    chk("R5 retry with start not counted", rd_data, 32'h0);
    step(6'b000100, 1'b0, 3'b0);
    chk("R5 third retry after start", rd_data, word_of(3'b100));

    // R6: window 0 acts as 1
    claim_window = 8'd0;
    step(6'b010000, 1'b0, 3'b0);
    step(6'b0, 1'b0, 3'b0);
    chk("R6 window zero", rd_data, word_of(3'b110));
    step(6'b000001, 1'b0, 3'b0);

    // R2: all flags set, layout
    chk("R2 layout", rd_data, 32'h0700_0000);

    // R10: enable masking
    irq_en = 3'b000;
    idle(2);
    chk("R10 all disabled", {31'b0, irq}, 32'h0);
    irq_en = 3'b001;
    idle(1);
    chk("R10 tabort enabled", {31'b0, irq}, 32'h1);
    step(6'b0, 1'b1, 3'b001);
    idle(1);
    chk("R10 masked after tabort cleared", {31'b0, irq}, 32'h0);
    chk("R8 partial clear", rd_data, word_of(3'b110));

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 reset clears flags", rd_data, 32'h0);
    chk("R1 reset clears irq", {31'b0, irq}, 32'h0);

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule